// File: doc/BRIEF.md
# Ordered Interrupt Acceptance Gate

This block sits between a pending maskable interrupt request and the CPU core and decides, every cycle, whether the request may be taken. The request carries a priority from 0 to NUM_PRIO-1, where a smaller number means more urgent. The block applies four acceptance conditions in a fixed order and stops at the first one that blocks the request. A mask status register records which condition did the blocking.

The first condition has two selectable sources. One is a per-priority in-service bitmap that the block maintains itself from acknowledge and return strobes. It gives a priority ceiling while handlers nest. The other is an explicit per-priority mask field supplied by the core. The remaining conditions are a priority level threshold, a global disable flag and a nesting-protect input. The global disable flag is held in a register that reset sets, so nothing is accepted until the core clears it.

Top module: `irq_accept_gate`

## Requirements
- R1: After reset, `isr_map` is all zeros, `mask_stat` is zero and `accept` is low even for a valid request, because the global disable flag resets to 1.
- R2: With `mask_src_sel`=0, a request of priority p is blocked at the first check when any `isr_map` bit with index less than or equal to p is set.
- R3: With `mask_src_sel`=1, `isr_map` has no effect on acceptance, and the first check blocks exactly when bit p of `expl_mask` is set.
- R4: The level check blocks a request whose priority p satisfies p >= `lvl_limit`, so `lvl_limit`=0 blocks everything and `lvl_limit`=NUM_PRIO blocks nothing.
- R5: The global disable flag is loaded from `gdis_din` on a cycle with `gdis_we`=1, takes effect from the next cycle, and blocks every request while it is 1.
- R6: `nest_block`=1 blocks a request that passed the three earlier checks.
- R7: Checks are evaluated in the order first check, level, global disable, nesting. `mask_stat` bit 0, 1, 2 and 3 marks them respectively. One cycle after a valid request, `mask_stat` has exactly the bit of the earliest blocking check set, or no bit if the request passed.
- R8: One cycle after a cycle with `req_vld`=0, `mask_stat` is zero.
- R9: `accept` is combinational and is high exactly when `req_vld`=1 and all four checks pass.
- R10: An `ack` strobe with `mask_src_sel`=0 sets bit `req_prio` of `isr_map` on the next cycle. With `mask_src_sel`=1 the strobe leaves the map unchanged.
- R11: A `ret` strobe clears the lowest-index set bit of `isr_map`. It has no effect on an empty map. When `ack` and `ret` occur in the same cycle, the clear is applied to the old map and the set is applied after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | A maskable request is pending |
| req_prio | input | PW | Priority of the pending request (0 most urgent) |
| mask_src_sel | input | 1 | 0: in-service bitmap is the first check; 1: explicit mask is |
| expl_mask | input | NUM_PRIO | Explicit per-priority mask |
| lvl_limit | input | PW+1 | Requests with priority >= this value are blocked |
| gdis_we | input | 1 | Load strobe for the global disable flag |
| gdis_din | input | 1 | Value loaded into the global disable flag |
| nest_block | input | 1 | Nesting-protect condition |
| ack | input | 1 | Core has taken the request at `req_prio` |
| ret | input | 1 | Core has returned from the most urgent active handler |
| accept | output | 1 | Request may be taken this cycle |
| mask_stat | output | 4 | Blocking condition of last cycle's request |
| isr_map | output | NUM_PRIO | In-service priority bitmap |

## Verification
The bench builds the block with its defaults: 16 priority levels, a 4-bit priority and a 5-bit level threshold. With these values both ends of the threshold are reachable: 0 blocks every request and 16 lets every request through. Directed phases stack handlers at several depths and place several blocking conditions on one request, so that only the earliest must show. A long random phase mixes `ack` and `ret` on the same cycle and switches the first-check source while handlers are active. A behavioural model is compared with the outputs every cycle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int unsigned CHK_NUM = 4;
  typedef enum logic [1:0] {
    CHK_FIRST = 2'd0,
    CHK_LEVEL = 2'd1,
    CHK_GDIS  = 2'd2,
    CHK_NEST  = 2'd3
  } chk_idx_e;
  typedef logic [CHK_NUM-1:0] chk_vec_t;
endpackage

// File: rtl/irq_inservice_map.sv
module irq_inservice_map #(
  parameter int unsigned NUM_PRIO = 16,
  localparam int unsigned PW = $clog2(NUM_PRIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [PW-1:0]       set_idx,
  input  logic                clr_en,
  output logic [NUM_PRIO-1:0] map_q
);
  logic [NUM_PRIO:0]   seen_below;
  logic [NUM_PRIO-1:0] clr_onehot;
  logic [NUM_PRIO-1:0] set_onehot;
  logic [NUM_PRIO-1:0] map_nxt;
  logic                map_en;

  assign seen_below[0] = 1'b0;

  // lowest set bit = most urgent active handler
  for (genvar i = 0; i < NUM_PRIO; i++) begin : g_lsb
    assign clr_onehot[i]   = map_q[i] & ~seen_below[i];
    assign seen_below[i+1] = seen_below[i] | map_q[i];
    assign set_onehot[i]   = (set_idx == PW'(i));
  end

  assign map_en = set_en | clr_en;

  always_comb begin
    map_nxt = map_q;
    if (clr_en) map_nxt = map_nxt & ~clr_onehot;
    if (set_en) map_nxt = map_nxt | set_onehot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= '0;
    else if (map_en) map_q <= map_nxt;
  end
endmodule

// File: rtl/irq_check_chain.sv
module irq_check_chain
  import irq_accept_pkg::*;
#(
  parameter int unsigned NUM_PRIO = 16,
  localparam int unsigned PW = $clog2(NUM_PRIO)
) (
  input  logic                req_vld,
  input  logic [PW-1:0]       req_prio,
  input  logic                mask_src_sel,
  input  logic [NUM_PRIO-1:0] isr_map,
  input  logic [NUM_PRIO-1:0] expl_mask,
  input  logic [PW:0]         lvl_limit,
  input  logic                gdis,
  input  logic                nest_block,
  output logic                pass,
  output chk_vec_t            stat_nxt
);
  logic [NUM_PRIO-1:0] ceil_win;
  chk_vec_t            blk;
  chk_vec_t            earlier_ok;

  for (genvar i = 0; i < NUM_PRIO; i++) begin : g_ceil
    assign ceil_win[i] = (PW'(i) <= req_prio);
  end

  assign blk[CHK_FIRST] = mask_src_sel ? expl_mask[req_prio]
                                       : |(isr_map & ceil_win);
  assign blk[CHK_LEVEL] = ({1'b0, req_prio} >= lvl_limit);
  assign blk[CHK_GDIS]  = gdis;
  assign blk[CHK_NEST]  = nest_block;

  // stop at the first blocking condition
  assign earlier_ok[0] = 1'b1;
  for (genvar c = 1; c < CHK_NUM; c++) begin : g_order
    assign earlier_ok[c] = earlier_ok[c-1] & ~blk[c-1];
  end

  assign stat_nxt = req_vld ? (blk & earlier_ok) : '0;
  assign pass     = req_vld & ~|blk;
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_accept_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     gdis_we,
  input  logic     gdis_din,
  input  chk_vec_t stat_nxt,
  output logic     gdis_q,
  output chk_vec_t stat_q
);
  logic gdis_nxt;

  assign gdis_nxt = gdis_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gdis_q <= 1'b1;
    else if (gdis_we) gdis_q <= gdis_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_accept_pkg::*;
#(
  parameter int unsigned NUM_PRIO = 16,
  localparam int unsigned PW = $clog2(NUM_PRIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_vld,
  input  logic [PW-1:0]       req_prio,
  input  logic                mask_src_sel,
  input  logic [NUM_PRIO-1:0] expl_mask,
  input  logic [PW:0]         lvl_limit,
  input  logic                gdis_we,
  input  logic                gdis_din,
  input  logic                nest_block,
  input  logic                ack,
  input  logic                ret,
  output logic                accept,
  output logic [CHK_NUM-1:0]  mask_stat,
  output logic [NUM_PRIO-1:0] isr_map
);
  logic     gdis_q;
  chk_vec_t stat_nxt;
  chk_vec_t stat_q;

  irq_inservice_map #(.NUM_PRIO(NUM_PRIO)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (ack & ~mask_src_sel),
    .set_idx (req_prio),
    .clr_en  (ret),
    .map_q   (isr_map)
  );

  irq_check_chain #(.NUM_PRIO(NUM_PRIO)) u_chain (
    .req_vld      (req_vld),
    .req_prio     (req_prio),
    .mask_src_sel (mask_src_sel),
    .isr_map      (isr_map),
    .expl_mask    (expl_mask),
    .lvl_limit    (lvl_limit),
    .gdis         (gdis_q),
    .nest_block   (nest_block),
    .pass         (accept),
    .stat_nxt     (stat_nxt)
  );

  irq_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .gdis_we  (gdis_we),
    .gdis_din (gdis_din),
    .stat_nxt (stat_nxt),
    .gdis_q   (gdis_q),
    .stat_q   (stat_q)
  );

  assign mask_stat = stat_q;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int unsigned NUM_PRIO = 16,
  localparam int unsigned PW = $clog2(NUM_PRIO)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_vld,
  input logic [PW-1:0]       req_prio,
  input logic                mask_src_sel,
  input logic [NUM_PRIO-1:0] expl_mask,
  input logic [PW:0]         lvl_limit,
  input logic                gdis_we,
  input logic                gdis_din,
  input logic                nest_block,
  input logic                ack,
  input logic                ret,
  input logic                accept,
  input logic [3:0]          mask_stat,
  input logic [NUM_PRIO-1:0] isr_map
);
  a_r7_stat_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_stat));

  a_r7_accept_clears_stat: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mask_stat == 4'd0));

  a_r8_idle_stat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (mask_stat == 4'd0));

  a_r9_accept_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> req_vld);

  a_r6_nest_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    nest_block |-> !accept);

  a_r4_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, req_prio} >= lvl_limit) |-> !accept);

  a_r3_expl_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_src_sel && expl_mask[req_prio]) |-> !accept);

  a_r10_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !mask_src_sel) |=> isr_map[$past(req_prio)]);

  a_r11_ret_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && (isr_map != '0)) |=>
      ($countones(isr_map) == $countones($past(isr_map)) - 1));

  a_r10_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret && !(ack && !mask_src_sel)) |=> $stable(isr_map));
endmodule

bind irq_accept_gate irq_accept_chk #(.NUM_PRIO(NUM_PRIO)) u_chk (.*);

// File: tb/test_irq_accept_gate.sv
`timescale 1ns/100ps
module test_irq_accept_gate;
  localparam int NP = 16;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_vld, mask_src_sel, gdis_we, gdis_din, nest_block, ack, ret;
  logic [PW-1:0] req_prio;
  logic [NP-1:0] expl_mask;
  logic [PW:0]   lvl_limit;
  logic          accept;
  logic [3:0]    mask_stat;
  logic [NP-1:0] isr_map;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // reference state
  bit m_isr[NP];
  bit m_dis;
  int m_stat;

  always #2.5 clk = ~clk;

  irq_accept_gate #(.NUM_PRIO(NP)) i_irq_accept_gate (.*);

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int first_block();
    int p = int'(req_prio);
    bit b0 = 1'b0;
    if (mask_src_sel) b0 = expl_mask[p];
    else for (int k = 0; k <= p; k++) if (m_isr[k]) b0 = 1'b1;
    if (b0) return 0;
    if (p >= int'(lvl_limit)) return 1;
    if (m_dis) return 2;
    if (nest_block) return 3;
    return -1;
  endfunction

  function automatic logic [NP-1:0] map_vec();
    logic [NP-1:0] v;
    for (int k = 0; k < NP; k++) v[k] = m_isr[k];
    return v;
  endfunction

  // compare outputs, then advance one clock and the model
  task automatic step(string tag);
    int fb;
    #1;
    fb = first_block();
    check(tag, "accept", accept, (req_vld && fb < 0) ? 1 : 0);
    check(tag, "mask_stat", mask_stat, m_stat);
    check(tag, "isr_map", isr_map, map_vec());
    @(posedge clk);
    m_stat = (req_vld && fb >= 0) ? (1 << fb) : 0;
    if (ret) begin
      for (int k = 0; k < NP; k++) if (m_isr[k]) begin m_isr[k] = 1'b0; break; end
    end
    if (ack && !mask_src_sel) m_isr[int'(req_prio)] = 1'b1;
    if (gdis_we) m_dis = gdis_din;
    @(negedge clk);
    gdis_we = 1'b0; ack = 1'b0; ret = 1'b0;
  endtask

  task automatic req(int p, string tag, bit a = 0, bit r = 0);
    req_vld = 1'b1; req_prio = PW'(p); ack = a; ret = r;
    step(tag);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_prio = '0; mask_src_sel = 1'b0;
    expl_mask = '0; lvl_limit = 5'd16; gdis_we = 1'b0; gdis_din = 1'b0;
    nest_block = 1'b0; ack = 1'b0; ret = 1'b0;
    foreach (m_isr[k]) m_isr[k] = 1'b0;
    m_dis = 1'b1; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, request refused by the reset-set disable flag
    req(2, "R1");
    req(2, "R1");  // R5 disable recorded in stat bit 2
    // R5: clear the disable flag
    req_vld = 1'b0; gdis_we = 1'b1; gdis_din = 1'b0; step("R5");
    req_vld = 1'b0; step("R8");
    // R10: take priority 5, then R2: same priority refused
    req(5, "R10", 1);
    req(5, "R2");
    req(9, "R2");
    req(3, "R10", 1);
    req(4, "R2");
    req(0, "R9");
    // R3: explicit mask selected, map ignored
    mask_src_sel = 1'b1; expl_mask = 16'h0000;
    req(4, "R3");
    req(7, "R3", 1);  // R10: no map change
    expl_mask = 16'h0080;
    req(7, "R3");
    req(6, "R3");
    mask_src_sel = 1'b0;
    // R4: level threshold edges
    lvl_limit = 5'd2; req(1, "R4"); req(2, "R4");
    lvl_limit = 5'd0; req(0, "R4");
    lvl_limit = 5'd16; req(1, "R4");
    // R7: several blocks at once, only earliest recorded
    lvl_limit = 5'd1; nest_block = 1'b1; req(4, "R7");
    req(2, "R7");
    gdis_we = 1'b1; gdis_din = 1'b1; req(0, "R7");
    req(0, "R7");
    gdis_we = 1'b1; gdis_din = 1'b0; req(0, "R6");
    req(0, "R6");
    nest_block = 1'b0; lvl_limit = 5'd16;
    req(0, "R9");
    // R11: returns peel off most urgent first
    req_vld = 1'b0; ret = 1'b1; step("R11");
    req(4, "R11");
    req_vld = 1'b0; ret = 1'b1; step("R11");
    req_vld = 1'b0; ret = 1'b1; step("R11");  // empty map
    req_vld = 1'b0; step("R8");
    req(6, "R11", 1);
    req(2, "R11", 1, 1);  // same-cycle return and take
    req(2, "R11", 1, 1);
    req_vld = 1'b0; step("R8");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      req_vld      = ($urandom_range(0, 3) != 0);
      req_prio     = PW'($urandom_range(0, NP - 1));
      mask_src_sel = ($urandom_range(0, 5) == 0);
      expl_mask    = NP'($urandom) & NP'($urandom);
      lvl_limit    = 5'($urandom_range(0, NP));
      nest_block   = ($urandom_range(0, 7) == 0);
      gdis_we      = ($urandom_range(0, 15) == 0);
      gdis_din     = ($urandom_range(0, 3) == 0);
      ack          = ($urandom_range(0, 3) == 0);
      ret          = ($urandom_range(0, 3) == 0);
      step("R7");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule